// File: doc/BRIEF.md
# Segmented Logical-to-Physical Address Mapper

This block widens a CPU's 16-bit logical address to a 21-bit external physical address. The logical space is cut into eight 8 KB segments. The top three logical bits pick one of eight 8-bit bank registers. The physical address is that bank number placed above the 13-bit offset inside the segment. The CPU core loads each bank register through a small write port and reads it back through a combinational read port.

Two fixed logical pages sit inside segment 1. Zero-page accesses use page $20 and stack accesses use page $21, with the low byte taken from an 8-bit index. An access-kind input selects a direct logical address or one of these two fixed pages. The translation path itself holds no state: the bank, the offset and the full physical address follow the effective logical address in the same cycle.

After reset only the top segment holds a defined mapping. It points at bank $00, so the vector area at the top of logical memory reaches physical $000000-$001FFF. The other seven registers also reset to $00, but a per-register flag reports them as never written.

Top module: `seg_addr_mapper`

## Requirements
- R1: While `rst` is high at a clock edge, every bank register becomes $00 and `defined` becomes 8'h80, meaning only register 7 counts as written.
- R2: For a direct access (`acc_kind` 0 or 3), `phys_bank` equals register `log_addr[15:13]`, `phys_off` equals `log_addr[12:0]`, and `phys_addr` equals {`phys_bank`, `phys_off`}, all in the same cycle.
- R3: With no writes since reset, logical $E000-$FFFF translates to physical $000000-$001FFF, and the vector addresses $FFF6-$FFFF translate to $001FF6-$001FFF.
- R4: A write with `wr_en` high changes the register on that clock edge. Readback and translation show the old value in the cycle of the write strobe and the new value from the next cycle on.
- R5: `rd_data` returns register `rd_sel` combinationally.
- R6: `acc_kind` 1 (zero page) forms logical {8'h20, `page_idx`}, and `acc_kind` 2 (stack) forms {8'h21, `page_idx`}. Both translate through register 1, and `eff_addr` shows the formed logical address.
- R7: A write to register n sets bit n of `defined`. The bit stays set until the next reset.
- R8: While `wr_en` is low, no bank register changes, whatever `wr_sel` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a bank register |
| wr_sel | input | 3 | Index of the register to write |
| wr_data | input | 8 | Bank number to write |
| rd_sel | input | 3 | Index of the register to read |
| rd_data | output | 8 | Contents of register `rd_sel` |
| defined | output | 8 | One bit per register, set once the register holds a defined value |
| acc_kind | input | 2 | 0 direct, 1 zero page, 2 stack, 3 direct |
| log_addr | input | 16 | Logical address for direct accesses |
| page_idx | input | 8 | Low byte for zero-page and stack accesses |
| eff_addr | output | 16 | Effective logical address being translated |
| phys_bank | output | 8 | Bank half of the physical address |
| phys_off | output | 13 | Offset half of the physical address |
| phys_addr | output | 21 | Full physical address |

## Verification
Translation, readback and `eff_addr` are combinational, so their values are due in the same cycle the inputs change. The bench drives each cycle at the falling edge and compares these outputs against its model 1 ns later, before the next rising edge. Register contents and `defined` change only at a rising edge. The model therefore applies a write after that cycle's comparison, which makes every write-strobe cycle check that the old value is still visible. Reset effects are checked in the first cycle after `rst` falls.

// File: rtl/seg_map_pkg.sv
package seg_map_pkg;
  typedef enum logic [1:0] {
    ACC_DIRECT = 2'd0,
    ACC_ZPAGE  = 2'd1,
    ACC_STACK  = 2'd2,
    ACC_ALT    = 2'd3
  } acc_kind_t;
endpackage

// File: rtl/seg_bank_regs.sv
module seg_bank_regs #(
  parameter int NSEG    = 8,
  parameter int BANK_W  = 8,
  parameter int DEF_SEG = NSEG - 1,
  localparam int SEL_W  = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BANK_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [BANK_W-1:0] rd_data,
  input  logic [SEL_W-1:0]  xl_sel,
  output logic [BANK_W-1:0] xl_bank,
  output logic [NSEG-1:0]   defined
);
  logic [NSEG-1:0][BANK_W-1:0] bank_q;
  logic [NSEG-1:0]             def_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      for (int s = 0; s < NSEG; s++) def_q[s] <= (s == DEF_SEG);
    end else if (wr_en) begin
      bank_q[wr_sel] <= wr_data;
      def_q[wr_sel]  <= 1'b1;
    end
  end

  assign rd_data = bank_q[rd_sel];
  assign xl_bank = bank_q[xl_sel];
  assign defined = def_q;

  // R4: a strobed write lands on the next edge
  p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> bank_q[$past(wr_sel)] == $past(wr_data));
  // R8: no strobe, no change
  p_hold_no_wr_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bank_q));
  // R7: defined bits never fall outside reset
  p_defined_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((def_q & $past(def_q)) == $past(def_q)));
  // R1: the top segment is always reported defined
  p_top_defined_r1: assert property (@(posedge clk) disable iff (rst)
    def_q[DEF_SEG]);
endmodule

// File: rtl/seg_fixed_page.sv
module seg_fixed_page #(
  parameter int LA_W     = 16,
  parameter int IDX_W    = 8,
  localparam int PG_W    = LA_W - IDX_W,
  parameter logic [PG_W-1:0] ZP_PAGE  = 8'h20,
  parameter logic [PG_W-1:0] STK_PAGE = 8'h21
) (
  input  seg_map_pkg::acc_kind_t kind,
  input  logic [LA_W-1:0]        log_addr,
  input  logic [IDX_W-1:0]       idx,
  output logic [LA_W-1:0]        eff_addr
);
  import seg_map_pkg::*;
  always_comb begin
    unique case (kind)
      ACC_ZPAGE: eff_addr = {ZP_PAGE, idx};
      ACC_STACK: eff_addr = {STK_PAGE, idx};
      default:   eff_addr = log_addr;
    endcase
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int LA_W   = 16,
  parameter int NSEG   = 8,
  parameter int BANK_W = 8,
  localparam int SEL_W = $clog2(NSEG),
  localparam int OFF_W = LA_W - SEL_W,
  localparam int PA_W  = BANK_W + OFF_W
) (
  input  logic [LA_W-1:0]   eff_addr,
  output logic [SEL_W-1:0]  seg_sel,
  input  logic [BANK_W-1:0] bank,
  output logic [BANK_W-1:0] phys_bank,
  output logic [OFF_W-1:0]  phys_off,
  output logic [PA_W-1:0]   phys_addr
);
  assign seg_sel   = eff_addr[LA_W-1 -: SEL_W];
  assign phys_bank = bank;
  assign phys_off  = eff_addr[OFF_W-1:0];
  assign phys_addr = {bank, eff_addr[OFF_W-1:0]};
endmodule

// File: rtl/seg_addr_mapper.sv
module seg_addr_mapper #(
  parameter int LA_W   = 16,
  parameter int NSEG   = 8,
  parameter int BANK_W = 8,
  parameter int IDX_W  = 8,
  localparam int SEL_W = $clog2(NSEG),
  localparam int OFF_W = LA_W - SEL_W,
  localparam int PA_W  = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BANK_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [BANK_W-1:0] rd_data,
  output logic [NSEG-1:0]   defined,
  input  logic [1:0]        acc_kind,
  input  logic [LA_W-1:0]   log_addr,
  input  logic [IDX_W-1:0]  page_idx,
  output logic [LA_W-1:0]   eff_addr,
  output logic [BANK_W-1:0] phys_bank,
  output logic [OFF_W-1:0]  phys_off,
  output logic [PA_W-1:0]   phys_addr
);
  import seg_map_pkg::*;

  acc_kind_t           kind;
  logic [SEL_W-1:0]    seg_sel;
  logic [BANK_W-1:0]   seg_bank;

  assign kind = acc_kind_t'(acc_kind);

  seg_fixed_page #(.LA_W(LA_W), .IDX_W(IDX_W)) u_page (
    .kind(kind), .log_addr(log_addr), .idx(page_idx), .eff_addr(eff_addr)
  );

  seg_bank_regs #(.NSEG(NSEG), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .xl_sel(seg_sel), .xl_bank(seg_bank),
    .defined(defined)
  );

  seg_xlate #(.LA_W(LA_W), .NSEG(NSEG), .BANK_W(BANK_W)) u_xlate (
    .eff_addr(eff_addr), .seg_sel(seg_sel), .bank(seg_bank),
    .phys_bank(phys_bank), .phys_off(phys_off), .phys_addr(phys_addr)
  );

  // R2: translated bank agrees with the readback of the same register
  p_bank_vs_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == eff_addr[LA_W-1 -: SEL_W]) |-> (phys_bank == rd_data));
  // R6: fixed pages always go through register 1
  p_fixed_via_seg1_r6: assert property (@(posedge clk) disable iff (rst)
    ((kind == ACC_ZPAGE || kind == ACC_STACK) && rd_sel == SEL_W'(1))
      |-> (phys_bank == rd_data));
endmodule

// File: tb/test_seg_addr_mapper.sv
module test_seg_addr_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic [7:0]  defined;
  logic [1:0]  acc_kind = '0;
  logic [15:0] log_addr = '0;
  logic [7:0]  page_idx = '0;
  logic [15:0] eff_addr;
  logic [7:0]  phys_bank;
  logic [12:0] phys_off;
  logic [20:0] phys_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_bank [8];
  logic [7:0] m_def;

  always #5 clk = ~clk;

  seg_addr_mapper i_seg_addr_mapper (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .defined(defined), .acc_kind(acc_kind),
    .log_addr(log_addr), .page_idx(page_idx), .eff_addr(eff_addr),
    .phys_bank(phys_bank), .phys_off(phys_off), .phys_addr(phys_addr)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_bank[i] = 0;
    m_def = 8'h80;
  endtask

  // one cycle: drive at falling edge, compare 1 ns later, then apply write to model
  task automatic step(bit we, int ws, int wd, int rs, int k, int la, int ix, string tag);
    logic [15:0] ea;
    string t_rd, t_xl;
    @(negedge clk);
    wr_en = we; wr_sel = 3'(ws); wr_data = 8'(wd); rd_sel = 3'(rs);
    acc_kind = 2'(k); log_addr = 16'(la); page_idx = 8'(ix);
    #1;
    if (k == 1) ea = {8'h20, 8'(ix)};
    else if (k == 2) ea = {8'h21, 8'(ix)};
    else ea = 16'(la);
    t_rd = (tag != "") ? tag : (we ? "R4 readback" : "R5");
    t_xl = (tag != "") ? tag : (k == 1 || k == 2) ? "R6" : (we ? "R4 xlate" : "R2");
    chk(t_rd, rd_data, m_bank[rs]);
    chk("R7", defined, m_def);
    chk(t_xl, eff_addr, ea);
    chk(t_xl, phys_bank, m_bank[ea[15:13]]);
    chk(t_xl, phys_off, ea[12:0]);
    chk(t_xl, phys_addr, {8'(m_bank[ea[15:13]]), ea[12:0]});
    if (we) begin
      m_bank[ws] = wd & 8'hFF;
      m_def[ws] = 1'b1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    model_reset();
    do_reset();
    // R1: reset state of every register and the defined flags
    for (int i = 0; i < 8; i++) step(0, 0, 0, i, 0, i << 13, 0, "R1");
    // R3: top segment and vectors after reset
    step(0, 0, 0, 7, 0, 16'hE000, 0, "R3");
    for (int v = 16'hFFF6; v <= 16'hFFFF; v++) step(0, 0, 0, 7, 0, v, 0, "R3");
    // R4: write strobe cycle still shows old value, next cycle shows new
    step(1, 3, 8'h5A, 3, 0, 16'h6123, 0, "");
    step(0, 0, 0, 3, 0, 16'h6123, 0, "R4 after");
    step(1, 7, 8'hC3, 7, 0, 16'hFFFC, 0, "");
    step(0, 0, 0, 7, 0, 16'hFFFC, 0, "R4 after");
    // R6: zero page and stack through register 1
    step(1, 1, 8'hF8, 1, 1, 0, 8'h00, "");
    step(0, 0, 0, 1, 1, 16'h9999, 8'h7F, "");
    step(0, 0, 0, 1, 2, 16'h0000, 8'hFF, "");
    step(0, 0, 0, 1, 3, 16'h2105, 8'h11, "");
    // R8: wr_en low with busy write inputs changes nothing
    for (int i = 0; i < 8; i++) step(0, i, 8'hEE, i, 0, i << 13, 0, "R8");
    // mixed random traffic compared every cycle
    for (int n = 0; n < 3000; n++)
      step(($urandom % 3) == 0, $urandom % 8, $urandom % 256, $urandom % 8,
           $urandom % 4, $urandom % 65536, $urandom % 256, "");
    // R1: reset in mid-run clears back to the reset state
    do_reset();
    for (int i = 0; i < 8; i++) step(0, 0, 0, i, 2, 0, i, "R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule